// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address that missed in the translation cache into a physical address by reading two entries from memory. It takes one request at a time from the requester, reads the first-level (directory) entry, checks that it is present, and only then reads the second-level (table) entry. It either answers with the table entry and the physical address, or with a page fault and the level at which the walk stopped. It does not write the accessed or dirty flags back to memory. Instead, it tells the requester whether each flag still has to be set.

The virtual address splits into a 10-bit directory index in bits 31:22, a 10-bit table index in bits 21:12 and a 12-bit page offset. Directories, tables and pages are each 4 KB. An entry is 4 bytes wide, so one table holds 1024 entries. The memory side is a read port that allows one read in flight: the address phase uses a valid/ready handshake, and the data returns later with its own valid strobe.

The controller steps through these states. Each arc is named after its trigger:
- IDLE to DIR_ADDR on accept.
- DIR_ADDR to DIR_DATA on address taken.
- DIR_DATA to TBL_ADDR on a present directory entry, or DIR_DATA to FAULT on a non-present one.
- TBL_ADDR to TBL_DATA on address taken.
- TBL_DATA to DONE on a present table entry, or TBL_DATA to FAULT on a non-present one.
- DONE or FAULT back to IDLE on response taken.

Top module: `pgwalk_engine`

## Requirements
- R1: `req_ready` is high only in IDLE, which is also the state after reset. While a response is pending or a walk is in progress, a raised `req_valid` starts nothing.
- R2: The first read, issued the cycle after acceptance, goes to `{dir_base[31:12], vaddr[31:22], 2'b00}`. The low 12 bits of `dir_base` are ignored.
- R3: After a present directory entry, the second read goes to `{pde[31:12], vaddr[21:12], 2'b00}`, whatever the directory entry's low 12 bits hold.
- R4: A read request keeps `mem_rd_valid` high and `mem_rd_addr` stable until `mem_rd_ready` is seen. Once the address is taken, no further read is requested until its data has returned.
- R5: A directory entry with bit 0 (present) clear ends the walk with `rsp_fault`=1 and `rsp_cause`=0, with no second read. `rsp_entry` carries that directory entry.
- R6: A table entry with bit 0 clear ends the walk with `rsp_fault`=1 and `rsp_cause`=1. `rsp_entry` carries that table entry.
- R7: On success, `rsp_fault`=0, `rsp_entry` is the table entry, and `rsp_paddr` = `{pte[31:12], vaddr[11:0]}`.
- R8: On success, `rsp_upd_acc` is 1 exactly when table-entry bit 5 (accessed) is clear. `rsp_upd_dirty` is 1 exactly when the access is a write and table-entry bit 6 (dirty) is clear. On a fault, both flags and `rsp_paddr` are 0.
- R9: A response stays valid and unchanged until `rsp_ready`. The cycle after it is taken, `rsp_valid` is low and `req_ready` is high.
- R10: Address, directory base and access type are captured at acceptance. Changing them afterwards does not affect the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Directory base register; bits 31:12 used |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access type: 1 write, 0 read |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | Page fault |
| rsp_cause | output | 1 | Fault level: 0 directory, 1 table |
| rsp_entry | output | 32 | Last entry read |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_upd_acc | output | 1 | Accessed flag must be set |
| rsp_upd_dirty | output | 1 | Dirty flag must be set |
| mem_rd_valid | output | 1 | Read address valid |
| mem_rd_ready | input | 1 | Memory takes the read address |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
Each result has a fixed latency, counted from a clock edge:
- The first read address is due one cycle after the acceptance edge.
- The second read address is due one cycle after the edge that delivers a present directory entry.
- The response is due one cycle after the edge that delivers the final entry.
- After a release, the block is idle again one cycle later.

The bench drives and samples on falling edges. At each of these exact points it checks the due value, then adds random address stalls, data latencies and response holds, and checks that nothing moves early or late. Expected addresses, frames and flag decisions come from bench functions applied to randomly drawn entries, mixed with directed cases at index extremes, non-present entries at either level, and dirty-flag combinations.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_DIR_ADDR = 3'd1,
        S_DIR_DATA = 3'd2,
        S_TBL_ADDR = 3'd3,
        S_TBL_DATA = 3'd4,
        S_DONE     = 3'd5,
        S_FAULT    = 3'd6
    } walk_state_t;

    typedef enum logic {
        CAUSE_DIR = 1'b0,
        CAUSE_TBL = 1'b1
    } fault_cause_t;

endpackage

// File: rtl/pgw_ctrl.sv
`timescale 1ns/1ps
module pgw_ctrl
    import pgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_rd_ready,
    input  logic        mem_rsp_valid,
    input  logic        entry_present,
    input  logic        rsp_ready,
    output walk_state_t state,
    output logic        req_ready,
    output logic        mem_rd_valid,
    output logic        sel_tbl,
    output logic        cap_req,
    output logic        cap_entry,
    output logic        tbl_phase,
    output logic        rsp_valid,
    output logic        rsp_done,
    output logic        rsp_is_fault
);

    walk_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (req_valid)     nxt = S_DIR_ADDR;
            S_DIR_ADDR: if (mem_rd_ready)  nxt = S_DIR_DATA;
            S_DIR_DATA: if (mem_rsp_valid) nxt = entry_present ? S_TBL_ADDR : S_FAULT;
            S_TBL_ADDR: if (mem_rd_ready)  nxt = S_TBL_DATA;
            S_TBL_DATA: if (mem_rsp_valid) nxt = entry_present ? S_DONE : S_FAULT;
            S_DONE,
            S_FAULT:    if (rsp_ready)     nxt = S_IDLE;
            default:                       nxt = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready    = (state == S_IDLE);
        mem_rd_valid = (state == S_DIR_ADDR) || (state == S_TBL_ADDR);
        sel_tbl      = (state == S_TBL_ADDR);
        cap_req      = (state == S_IDLE) && req_valid;
        tbl_phase    = (state == S_TBL_DATA);
        cap_entry    = ((state == S_DIR_DATA) || (state == S_TBL_DATA)) && mem_rsp_valid;
        rsp_done     = (state == S_DONE);
        rsp_is_fault = (state == S_FAULT);
        rsp_valid    = rsp_done || rsp_is_fault;
    end

endmodule

// File: rtl/pgw_addr_form.sv
`timescale 1ns/1ps
module pgw_addr_form #(
    parameter int unsigned FRAME_W  = 20,
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned ENT_LOG2 = 2
) (
    input  logic [FRAME_W-1:0]                  frame,
    input  logic [IDX_W-1:0]                    index,
    output logic [FRAME_W+IDX_W+ENT_LOG2-1:0]   addr
);

    // table base (4 KB aligned) plus index times entry size
    assign addr = {frame, index, {ENT_LOG2{1'b0}}};

endmodule

// File: rtl/pgw_datapath.sv
`timescale 1ns/1ps
module pgw_datapath
    import pgw_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_LOG2 = 12,
    parameter int unsigned ENT_LOG2  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_req,
    input  logic                 cap_entry,
    input  logic                 tbl_phase,
    input  logic                 sel_tbl,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [VA_W-1:0]      dir_base,
    input  logic                 req_write,
    input  logic [VA_W-1:0]      mem_rsp_data,
    output logic [VA_W-1:0]      rd_addr,
    output logic [VA_W-1:0]      entry_q,
    output logic [PAGE_LOG2-1:0] offset_q,
    output logic                 write_q,
    output fault_cause_t         cause_q
);

    localparam int unsigned IDX_W   = PAGE_LOG2 - ENT_LOG2;
    localparam int unsigned FRAME_W = VA_W - PAGE_LOG2;
    localparam int unsigned DIR_LO  = PAGE_LOG2 + IDX_W;

    logic [VA_W-1:0]    vaddr_q;
    logic [FRAME_W-1:0] base_q;
    logic [FRAME_W-1:0] frame_sel;
    logic [IDX_W-1:0]   idx_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            base_q  <= '0;
            write_q <= 1'b0;
            entry_q <= '0;
            cause_q <= CAUSE_DIR;
        end else begin
            if (cap_req) begin
                vaddr_q <= req_vaddr;
                base_q  <= dir_base[VA_W-1:PAGE_LOG2];
                write_q <= req_write;
            end
            if (cap_entry) begin
                entry_q <= mem_rsp_data;
                cause_q <= tbl_phase ? CAUSE_TBL : CAUSE_DIR;
            end
        end
    end

    always_comb begin
        if (sel_tbl) begin
            frame_sel = entry_q[VA_W-1:PAGE_LOG2];
            idx_sel   = vaddr_q[DIR_LO-1:PAGE_LOG2];
        end else begin
            frame_sel = base_q;
            idx_sel   = vaddr_q[VA_W-1:DIR_LO];
        end
    end

    pgw_addr_form #(
        .FRAME_W (FRAME_W),
        .IDX_W   (IDX_W),
        .ENT_LOG2(ENT_LOG2)
    ) u_addr (
        .frame(frame_sel),
        .index(idx_sel),
        .addr (rd_addr)
    );

    assign offset_q = vaddr_q[PAGE_LOG2-1:0];

endmodule

// File: rtl/pgwalk_engine.sv
`timescale 1ns/1ps
module pgwalk_engine
    import pgw_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_LOG2 = 12,
    parameter int unsigned ENT_LOG2  = 2,
    parameter int unsigned PRES_BIT  = 0,
    parameter int unsigned ACC_BIT   = 5,
    parameter int unsigned DIRTY_BIT = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] dir_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic            rsp_fault,
    output logic            rsp_cause,
    output logic [VA_W-1:0] rsp_entry,
    output logic [VA_W-1:0] rsp_paddr,
    output logic            rsp_upd_acc,
    output logic            rsp_upd_dirty,
    output logic            mem_rd_valid,
    input  logic            mem_rd_ready,
    output logic [VA_W-1:0] mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data
);

    walk_state_t          state;
    logic                 sel_tbl;
    logic                 cap_req;
    logic                 cap_entry;
    logic                 tbl_phase;
    logic                 rsp_done;
    logic                 rsp_is_fault;
    logic [VA_W-1:0]      entry_q;
    logic [PAGE_LOG2-1:0] offset_q;
    logic                 write_q;
    fault_cause_t         cause_q;

    pgw_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .entry_present(mem_rsp_data[PRES_BIT]),
        .rsp_ready    (rsp_ready),
        .state        (state),
        .req_ready    (req_ready),
        .mem_rd_valid (mem_rd_valid),
        .sel_tbl      (sel_tbl),
        .cap_req      (cap_req),
        .cap_entry    (cap_entry),
        .tbl_phase    (tbl_phase),
        .rsp_valid    (rsp_valid),
        .rsp_done     (rsp_done),
        .rsp_is_fault (rsp_is_fault)
    );

    pgw_datapath #(
        .VA_W     (VA_W),
        .PAGE_LOG2(PAGE_LOG2),
        .ENT_LOG2 (ENT_LOG2)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_req     (cap_req),
        .cap_entry   (cap_entry),
        .tbl_phase   (tbl_phase),
        .sel_tbl     (sel_tbl),
        .req_vaddr   (req_vaddr),
        .dir_base    (dir_base),
        .req_write   (req_write),
        .mem_rsp_data(mem_rsp_data),
        .rd_addr     (mem_rd_addr),
        .entry_q     (entry_q),
        .offset_q    (offset_q),
        .write_q     (write_q),
        .cause_q     (cause_q)
    );

    always_comb begin
        rsp_fault     = rsp_is_fault;
        rsp_cause     = rsp_is_fault && (cause_q == CAUSE_TBL);
        rsp_entry     = rsp_valid ? entry_q : '0;
        rsp_paddr     = '0;
        rsp_upd_acc   = 1'b0;
        rsp_upd_dirty = 1'b0;
        if (rsp_done) begin
            rsp_paddr     = {entry_q[VA_W-1:PAGE_LOG2], offset_q};
            rsp_upd_acc   = !entry_q[ACC_BIT];
            rsp_upd_dirty = write_q && !entry_q[DIRTY_BIT];
        end
    end

endmodule

// File: rtl/pgw_checker.sv
`timescale 1ns/1ps
module pgw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic        rsp_fault,
    input logic        rsp_cause,
    input logic [31:0] rsp_paddr,
    input logic [31:0] rsp_entry,
    input logic        rsp_upd_acc,
    input logic        rsp_upd_dirty,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr
);

    logic [1:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_cnt <= 2'd0;
        else if (req_valid && req_ready)     rd_cnt <= 2'd0;
        else if (mem_rd_valid && mem_rd_ready && rd_cnt != 2'd3)
                                             rd_cnt <= rd_cnt + 2'd1;
    end

    AST_IDLE_XOR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));                                              // R1
    AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_valid && !req_ready));              // R2
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);                       // R4
    AST_DIR_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !rsp_cause) |-> (rd_cnt == 2'd1));            // R5
    AST_TBL_FAULT_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && rsp_cause) |-> (rd_cnt == 2'd2));             // R6
    AST_DONE_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rd_cnt == 2'd2));                         // R7
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'd0 && !rsp_upd_acc && !rsp_upd_dirty)); // R8
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr)
                                       && $stable(rsp_entry)));                  // R9
    AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));                 // R9

endmodule

bind pgwalk_engine pgw_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_fault    (rsp_fault),
    .rsp_cause    (rsp_cause),
    .rsp_paddr    (rsp_paddr),
    .rsp_entry    (rsp_entry),
    .rsp_upd_acc  (rsp_upd_acc),
    .rsp_upd_dirty(rsp_upd_dirty),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr)
);

// File: tb/sim_pgwalk_engine.sv
`timescale 1ns/1ps
module sim_pgwalk_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dir_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic        rsp_cause;
    logic [31:0] rsp_entry;
    logic [31:0] rsp_paddr;
    logic        rsp_upd_acc;
    logic        rsp_upd_dirty;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    pgwalk_engine u0 (
        .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_entry(rsp_entry), .rsp_paddr(rsp_paddr),
        .rsp_upd_acc(rsp_upd_acc), .rsp_upd_dirty(rsp_upd_dirty),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] f_dir_addr(logic [31:0] base, logic [31:0] va);
        return {base[31:12], va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] f_tbl_addr(logic [31:0] pde, logic [31:0] va);
        return {pde[31:12], va[21:12], 2'b00};
    endfunction

    function automatic logic [31:0] f_paddr(logic [31:0] pte, logic [31:0] va);
        return {pte[31:12], va[11:0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one memory read: address phase with stalls, then data after a latency
    task automatic mem_read(string tag, logic [31:0] exp_addr, logic [31:0] data,
                            int stall, int lat);
        chk({tag, " rd_valid"}, {31'd0, mem_rd_valid}, 32'd1);
        chk({tag, " rd_addr"}, mem_rd_addr, exp_addr);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk("R4 rd_valid held", {31'd0, mem_rd_valid}, 32'd1);
            chk("R4 rd_addr stable", mem_rd_addr, exp_addr);
        end
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        chk("R4 no second read in flight", {31'd0, mem_rd_valid}, 32'd0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk("R4 still waiting", {30'd0, mem_rd_valid, rsp_valid}, 32'd0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = $urandom;
    endtask

    task automatic walk(logic [31:0] va, logic [31:0] base, logic wr,
                        logic [31:0] pde, logic [31:0] pte,
                        int stall, int lat, int hold);
        @(negedge clk);
        chk("R1 idle before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        dir_base  = base;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = $urandom;   // R10: later changes must not matter
        dir_base  = $urandom;
        req_write = ~wr;
        chk("R1 busy after accept", {31'd0, req_ready}, 32'd0);
        mem_read("R2", f_dir_addr(base, va), pde, stall, lat);
        if (!pde[0]) begin
            chk("R5 fault valid", {30'd0, rsp_valid, rsp_fault}, 32'd3);
            chk("R5 cause dir", {31'd0, rsp_cause}, 32'd0);
            chk("R5 entry", rsp_entry, pde);
            chk("R5 no table read", {31'd0, mem_rd_valid}, 32'd0);
            chk("R8 fault clean", {rsp_paddr[29:0], rsp_upd_acc, rsp_upd_dirty}, 32'd0);
        end else begin
            mem_read("R3", f_tbl_addr(pde, va), pte, lat % 3, stall);
            chk("R7 rsp valid", {31'd0, rsp_valid}, 32'd1);
            if (!pte[0]) begin
                chk("R6 fault", {31'd0, rsp_fault}, 32'd1);
                chk("R6 cause table", {31'd0, rsp_cause}, 32'd1);
                chk("R6 entry", rsp_entry, pte);
                chk("R8 fault paddr", rsp_paddr, 32'd0);
                chk("R8 fault flags", {30'd0, rsp_upd_acc, rsp_upd_dirty}, 32'd0);
            end else begin
                chk("R7 no fault", {31'd0, rsp_fault}, 32'd0);
                chk("R7 entry", rsp_entry, pte);
                chk("R7 R10 paddr", rsp_paddr, f_paddr(pte, va));
                chk("R8 upd_acc", {31'd0, rsp_upd_acc}, {31'd0, !pte[5]});
                chk("R8 R10 upd_dirty", {31'd0, rsp_upd_dirty}, {31'd0, wr && !pte[6]});
            end
        end
        for (int i = 0; i < hold; i++) begin
            req_valid = 1'b1;
            @(negedge clk);
            chk("R9 rsp held", {31'd0, rsp_valid}, 32'd1);
            chk("R1 no accept while pending", {31'd0, req_ready}, 32'd0);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R9 released", {30'd0, rsp_valid, req_ready}, 32'd1);
        chk("R1 no stray start", {31'd0, mem_rd_valid}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        chk("R1 reset idle", {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'd4);

        // directed corners
        walk(32'h0000_0000, 32'h0012_3FFF, 1'b0, 32'h0004_5001, 32'h0ABC_D061, 0, 0, 0);
        walk(32'hFFFF_FFFF, 32'hFFFF_F000, 1'b1, 32'hFFFF_FFFF, 32'h1234_5001, 2, 3, 2);
        walk(32'h8040_2ABC, 32'h0010_0000, 1'b1, 32'h0020_0FFE, 32'h0, 1, 1, 1);
        walk(32'h8040_2ABC, 32'h0010_0000, 1'b0, 32'h0020_0001, 32'h0030_0FFE, 0, 2, 0);
        walk(32'h1234_5678, 32'h0000_0000, 1'b1, 32'h0000_1001, 32'hCAFE_F041, 3, 0, 1);
        walk(32'h1234_5678, 32'h0000_0000, 1'b1, 32'h0000_1001, 32'hCAFE_F021, 0, 0, 0);

        // random walks
        for (int n = 0; n < 300; n++) begin
            logic [31:0] pde;
            logic [31:0] pte;
            pde = $urandom;
            pte = $urandom;
            pde[0] = ($urandom % 5) != 0;
            pte[0] = ($urandom % 5) != 0;
            walk($urandom, $urandom, 1'($urandom), pde, pte,
                 int'($urandom % 4), int'($urandom % 4), int'($urandom % 3));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule